// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Bank

This block owns a bank of 32 pad lines behind a 32-bit register port. Software sets each line up as one of three things: a plain input, a plain output, or an interrupt source. A plain output drives its pad from a data register and enables the pad driver. A plain input is read back through a two-flop synchroniser. An interrupt source has three per-line controls. The first picks active-high or active-low sense. The second picks level or edge detection. The third, used only in edge mode, widens detection to both edges.

Detected events land in a status register. A line in edge mode keeps its status bit until software clears it. A line in level mode has a status bit that tracks the pin. The mask can be loaded whole in one write, or bits can be turned on with a separate write-one-to-enable register. The single interrupt output is high while any status bit meets an enabled mask bit.

The bus is a write strobe with a word index. Read data is combinational from the index, so a read costs no cycle. The table below gives each register by word index, with the byte offset in brackets:

- 0 (0x00) mode: 1 = interrupt line.
- 1 (0x04) direction: 1 = output.
- 2 (0x08) output data.
- 3 (0x0C) input data, read only.
- 4 (0x10) status, read only.
- 5 (0x14) clear, write only.
- 6 (0x18) mask.
- 7 (0x1C) unmask, write only.
- 8 (0x20) polarity.
- 9 (0x24) edge select.
- 10 (0x28) filter enable.
- 16 (0x40) drive source.
- 19 (0x4C) both-edge.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, `pad_oe` and `pad_out` are 0, and `irq` is 0.
- R2: Input data (index 3) returns `pad_in` through two flops, so a pad change shows on a read after the second rising edge.
- R3: `pad_oe` bit i is 1 exactly when direction bit i is 1 and mode bit i is 0.
- R4: With drive-source bit i = 0, `pad_out` bit i equals output data bit i. With drive-source bit i = 1, `pad_out` bit i is 0.
- R5: In level mode (mode = 1, edge select = 0), status bit i becomes the synchronised pin XOR polarity bit i at the third rising edge after the pad change, and follows the pin every cycle after that.
- R6: Polarity bit 1 selects active-low in level mode and falling edges in edge mode. Polarity bit 0 selects active-high and rising edges.
- R7: In edge mode (edge select = 1), status bit i sets on a detected edge at the third rising edge after the pad change and holds until cleared. An edge that lands in the same cycle as a clear of that bit leaves it set.
- R8: A write to clear (index 5) clears the status bits written as 1 and leaves the bits written as 0 unchanged. Reading index 5 returns 0.
- R9: With both-edge bit i = 1 in edge mode, rising and falling edges both set status bit i, whatever the polarity.
- R10: A write to mask (index 6) loads all 32 mask bits with the written word. Mask 1 = enabled.
- R11: A write to unmask (index 7) sets the mask bits written as 1 and leaves the others unchanged. Reading index 7 returns 0.
- R12: `irq` is 1 exactly when status AND mask is non-zero. Status is readable at index 4.
- R13: Status bits of lines with mode = 0 stay 0. The filter-enable word reads back as written. Reads of unlisted indexes return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Raw pad input levels |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables |
| irq | output | 1 | Combined interrupt, active high |

## Verification
Each result has a fixed latency, and every check samples at a falling clock edge in that cycle:

- Register writes land on the rising edge that ends the strobe cycle. `pad_oe` and `pad_out` change in that same cycle.
- Input data changes two rising edges after a pad change.
- Status and `irq` change three rising edges after a pad change. The bench first confirms the old value after two edges, then checks the new value after the third.
- For the clear-versus-edge race, the clear strobe is held across exactly the third edge after the pad rise, so both act at the same edge.

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int LINES  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LINES-1:0]  bus_wdata,
  output logic [LINES-1:0]  bus_rdata,
  input  logic [LINES-1:0]  pad_in,
  output logic [LINES-1:0]  pad_out,
  output logic [LINES-1:0]  pad_oe,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] IX_MODE  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] IX_DIR   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] IX_DOUT  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] IX_DIN   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] IX_STAT  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] IX_CLR   = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] IX_MASK  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] IX_UNMSK = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] IX_POL   = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] IX_EDGE  = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] IX_FILT  = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] IX_SRC   = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] IX_BOTH  = ADDR_W'(19);

  logic [LINES-1:0] iosel_q, dir_q, dout_q, msk_q, pol_q, edg_q, filt_q, src_q, both_q;
  logic [LINES-1:0] stat_q, sy1_q, sy2_q, sy3_q;
  logic [LINES-1:0] lvl, rise, fall, ev, clr, stat_nx;

  assign clr     = (bus_we && bus_addr == IX_CLR) ? bus_wdata : '0;
  assign lvl     = sy2_q ^ pol_q;
  assign rise    = sy2_q & ~sy3_q;
  assign fall    = ~sy2_q & sy3_q;
  assign ev      = (both_q & (rise | fall)) | (~both_q & ((~pol_q & rise) | (pol_q & fall)));
  assign stat_nx = iosel_q & ((~edg_q & lvl) | (edg_q & (ev | (stat_q & ~clr))));

  assign pad_oe  = dir_q & ~iosel_q;
  assign pad_out = dout_q & ~src_q;
  assign irq     = |(stat_q & msk_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1_q <= '0;
      sy2_q <= '0;
      sy3_q <= '0;
      stat_q <= '0;
    end else begin
      sy1_q <= pad_in;
      sy2_q <= sy1_q;
      sy3_q <= sy2_q;
      stat_q <= stat_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iosel_q <= '0; dir_q <= '0; dout_q <= '0; msk_q <= '0; pol_q <= '0;
      edg_q <= '0; filt_q <= '0; src_q <= '0; both_q <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        IX_MODE:  iosel_q <= bus_wdata;
        IX_DIR:   dir_q   <= bus_wdata;
        IX_DOUT:  dout_q  <= bus_wdata;
        IX_MASK:  msk_q   <= bus_wdata;
        IX_UNMSK: msk_q   <= msk_q | bus_wdata;
        IX_POL:   pol_q   <= bus_wdata;
        IX_EDGE:  edg_q   <= bus_wdata;
        IX_FILT:  filt_q  <= bus_wdata;
        IX_SRC:   src_q   <= bus_wdata;
        IX_BOTH:  both_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      IX_MODE: bus_rdata = iosel_q;
      IX_DIR:  bus_rdata = dir_q;
      IX_DOUT: bus_rdata = dout_q;
      IX_DIN:  bus_rdata = sy2_q;
      IX_STAT: bus_rdata = stat_q;
      IX_MASK: bus_rdata = msk_q;
      IX_POL:  bus_rdata = pol_q;
      IX_EDGE: bus_rdata = edg_q;
      IX_FILT: bus_rdata = filt_q;
      IX_SRC:  bus_rdata = src_q;
      IX_BOTH: bus_rdata = both_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int LINES  = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [LINES-1:0]  bus_wdata,
  input logic [LINES-1:0]  pad_oe,
  input logic [LINES-1:0]  iosel_q,
  input logic [LINES-1:0]  edg_q,
  input logic [LINES-1:0]  stat_q,
  input logic [LINES-1:0]  msk_q
);
  logic mask_wr, unmask_wr;
  logic [LINES-1:0] clr_w;
  assign mask_wr   = bus_we && bus_addr == ADDR_W'(6);
  assign unmask_wr = bus_we && bus_addr == ADDR_W'(7);
  assign clr_w     = (bus_we && bus_addr == ADDR_W'(5)) ? bus_wdata : '0;

  a_r3_oe_only_in_gpio_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & iosel_q) == '0);

  a_r10_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> msk_q == $past(bus_wdata));

  a_r11_unmask_sets: assert property (@(posedge clk) disable iff (!rst_n)
    unmask_wr |=> (msk_q & $past(bus_wdata)) == $past(bus_wdata));

  a_r11_unmask_keeps_rest: assert property (@(posedge clk) disable iff (!rst_n)
    unmask_wr |=> ((msk_q ^ $past(msk_q)) & ~$past(bus_wdata)) == '0);

  a_r7_edge_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat_q) & $past(edg_q) & $past(iosel_q) & ~$past(clr_w)) & ~stat_q) == '0);

  a_r13_gpio_lines_no_status: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat_q & ~$past(iosel_q)) == '0);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.LINES(LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .pad_oe(pad_oe), .iosel_q(iosel_q), .edg_q(edg_q), .stat_q(stat_q), .msk_q(msk_q)
);

// File: tb/sim_gpio_irq_bank.sv
module sim_gpio_irq_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_bank u0 (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pads(input logic [31:0] v);
    @(negedge clk);
    pad_in = v;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int i = 0; i < 32; i++) begin
      rd(5'(i), d);
      chk("R1 reg after reset", d, 32'h0);
    end
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 pad_out", pad_out, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_output();
    wr(5'd2, 32'h0000_FF00);
    wr(5'd1, 32'h0000_FF00);
    chk("R3 pad_oe follows direction", pad_oe, 32'h0000_FF00);
    chk("R4 pad_out from data", pad_out, 32'h0000_FF00);
    wr(5'd16, 32'h0000_0F00);
    chk("R4 source bit masks pad_out", pad_out, 32'h0000_F000);
    wr(5'd0, 32'h0000_0100);
    chk("R3 interrupt mode drops pad_oe", pad_oe, 32'h0000_FE00);
    wr(5'd0, 32'h0);
    wr(5'd16, 32'h0);
  endtask

  task automatic t_input();
    logic [31:0] d;
    pads(32'hA5A5_0000);
    @(posedge clk);
    @(negedge clk);
    bus_addr = 5'd3;
    #1 chk("R2 input after one edge still old", bus_rdata, 32'h0);
    @(posedge clk);
    @(negedge clk);
    #1 chk("R2 input after two edges", bus_rdata, 32'hA5A5_0000);
    rd(5'd3, d);
    chk("R2 input readback", d, 32'hA5A5_0000);
  endtask

  task automatic t_level();
    logic [31:0] d;
    pads(32'hA5A5_0004);
    wr(5'd8, 32'h0000_0006);
    wr(5'd9, 32'h0000_001C);
    wr(5'd19, 32'h0000_0008);
    wr(5'd0, 32'h0000_001F);
    settle();
    wr(5'd5, 32'h0000_001C);
    wr(5'd7, 32'h0000_001F);
    rd(5'd4, d);
    chk("R6 level-low line active", d, 32'h0000_0002);
    chk("R12 irq on enabled status", {31'h0, irq}, 32'h1);
    pads(32'hA5A5_0005);
    repeat (2) @(posedge clk);
    @(negedge clk);
    bus_addr = 5'd4;
    #1 chk("R5 status not yet after two edges", bus_rdata, 32'h0000_0002);
    @(posedge clk);
    @(negedge clk);
    #1 chk("R5 level-high status at third edge", bus_rdata, 32'h0000_0003);
    pads(32'hA5A5_0007);
    settle();
    rd(5'd4, d);
    chk("R6 level-low goes idle on high pin", d, 32'h0000_0001);
    wr(5'd5, 32'h0000_0001);
    rd(5'd4, d);
    chk("R5 level status follows pin after clear", d, 32'h0000_0001);
    pads(32'hA5A5_0006);
    settle();
    rd(5'd4, d);
    chk("R5 level status drops", d, 32'h0000_0000);
    chk("R12 irq low with empty status", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    pads(32'hA5A5_0016);
    settle();
    rd(5'd4, d);
    chk("R7 rising edge latched", d, 32'h0000_0010);
    wr(5'd5, 32'h0000_000F);
    rd(5'd4, d);
    chk("R8 zero bits of clear keep status", d, 32'h0000_0010);
    pads(32'hA5A5_0006);
    settle();
    rd(5'd4, d);
    chk("R7 status sticky after pin falls", d, 32'h0000_0010);
    wr(5'd5, 32'h0000_0010);
    rd(5'd4, d);
    chk("R8 clear removes status", d, 32'h0000_0000);
    rd(5'd5, d);
    chk("R8 clear index reads zero", d, 32'h0);
    pads(32'hA5A5_0016);
    @(posedge clk);
    @(posedge clk);
    wr(5'd5, 32'h0000_0010);
    rd(5'd4, d);
    chk("R7 edge wins over same-cycle clear", d, 32'h0000_0010);
    wr(5'd5, 32'h0000_0010);
    rd(5'd4, d);
    chk("R7 cleared afterwards", d, 32'h0000_0000);
  endtask

  task automatic t_fall();
    logic [31:0] d;
    pads(32'hA5A5_0012);
    settle();
    rd(5'd4, d);
    chk("R6 falling edge latched", d, 32'h0000_0004);
    wr(5'd5, 32'h0000_0004);
    pads(32'hA5A5_0016);
    settle();
    rd(5'd4, d);
    chk("R6 rising edge ignored on falling line", d, 32'h0000_0000);
  endtask

  task automatic t_both();
    logic [31:0] d;
    pads(32'hA5A5_001E);
    settle();
    rd(5'd4, d);
    chk("R9 both-edge catches rise", d, 32'h0000_0008);
    wr(5'd5, 32'h0000_0008);
    pads(32'hA5A5_0016);
    settle();
    rd(5'd4, d);
    chk("R9 both-edge catches fall", d, 32'h0000_0008);
    wr(5'd5, 32'h0000_0008);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    pads(32'hA5A5_0006);
    pads(32'hA5A5_0016);
    settle();
    chk("R12 irq from edge line", {31'h0, irq}, 32'h1);
    wr(5'd6, 32'hFFFF_FFEF);
    rd(5'd6, d);
    chk("R10 mask loads whole word", d, 32'hFFFF_FFEF);
    chk("R10 masked line gives no irq", {31'h0, irq}, 32'h0);
    wr(5'd7, 32'h0000_0010);
    rd(5'd6, d);
    chk("R11 unmask sets only written ones", d, 32'hFFFF_FFFF);
    chk("R12 irq back after unmask", {31'h0, irq}, 32'h1);
    wr(5'd6, 32'h0000_0001);
    wr(5'd7, 32'h0000_0100);
    rd(5'd6, d);
    chk("R11 unmask keeps other bits", d, 32'h0000_0101);
    rd(5'd7, d);
    chk("R11 unmask index reads zero", d, 32'h0);
    wr(5'd5, 32'h0000_0010);
  endtask

  task automatic t_misc();
    logic [31:0] d;
    wr(5'd10, 32'h1234_5678);
    rd(5'd10, d);
    chk("R13 filter word reads back", d, 32'h1234_5678);
    rd(5'd11, d);
    chk("R13 unlisted index reads zero", d, 32'h0);
    rd(5'd31, d);
    chk("R13 top index reads zero", d, 32'h0);
    wr(5'd7, 32'hFFFF_FFFF);
    pads(32'hA5A5_0036);
    settle();
    pads(32'hA5A5_0016);
    settle();
    rd(5'd4, d);
    chk("R13 gpio-mode line never sets status", d, 32'h0);
    chk("R13 no irq from gpio-mode line", {31'h0, irq}, 32'h0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_output();
    t_input();
    t_level();
    t_rise();
    t_fall();
    t_both();
    t_mask();
    t_misc();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule